// File: doc/BRIEF.md
# ATA Task File Register Block

This block is the device-side register file of an ATA-style storage target. A host reaches it over a small register bus. The bus has a 3-bit offset, a control-block select, separate read and write strobes, a byte-access qualifier and a 16-bit data path. Writes land at the clock edge. Read data is combinational from the current register state, and a read's side effect (clearing the interrupt) takes hold at the edge that ends the read cycle.

The block keeps the addressing parameters of a transfer: sector count, sector number, the two cylinder bytes and the drive/head byte. From these it presents a 28-bit logical block address or a cylinder/head/sector triple, and an effective count in which zero means 256. It composes the status byte from its own busy and error state and the engine's data-request line. It returns an error byte whose source depends on the last command. It raises and clears the interrupt request and runs a register-level soft reset. It hands each accepted command to the command engine as a one-cycle strobe. The engine, the media and the sector buffer sit outside. They appear only as a completion pulse with an error flag, a data-request level, three code bytes, and a word-load port into the data register.

Top module: `tfile_regs`

## Requirements
- R1: The data register (offset 0, control select 0) holds 16 bits. A word write stores all 16 bits. A write with `bus_byte`=1 replaces bits 7:0 only and keeps bits 15:8. A read with `bus_byte`=1 returns bits 7:0 with the upper byte zero. A pulse on `xfer_load` loads `xfer_in` into the register.
- R2: `sec_count` equals the sector count register (offset 2), except that a stored value of 0 gives 256.
- R3: When drive/head (offset 6) bit 6 is 1, `addr_is_lba`=1 and `lba_addr` = {drive/head[3:0], cylinder high (offset 5), cylinder low (offset 4), sector number (offset 3)}.
- R4: When drive/head bit 6 is 0, `chs_cyl` = {cylinder high, cylinder low}, `chs_head` = drive/head[3:0], `chs_sector` = sector number, and `lba_addr` is 0. In LBA mode the three CHS outputs are 0.
- R5: A read at offset 7 (control select 0) returns status and clears the pending interrupt. A read at offset 6 with control select 1 returns the same byte and leaves the interrupt unchanged.
- R6: The pending interrupt is set by `eng_done` while a command is busy. `intrq` is the pending flag masked by the interrupt-disable bit (device control bit 1). Writing that bit back to 0 exposes a request that is still pending. `eng_done` with no busy command has no effect.
- R7: Device control (offset 6, control select 1, write-only) bit 2 is soft reset. While it is 1, `dev_reset`=1 and status reads 80h. The task file registers read 0, and writes to them are ignored. Command writes are dropped and the pending interrupt is cleared. Writing the bit back to 0 leaves the task file at 0 and status at 40h.
- R8: A command write (offset 7, control select 0) while not busy raises `cmd_go` for exactly one cycle, starting at the edge after the write, with `cmd_code` equal to the written byte. It sets BSY and clears ERR and the pending interrupt. A command write while busy is ignored.
- R9: The status layout is bit 7 BSY, bit 6 DRDY, bit 3 DRQ (follows `eng_drq`), bit 0 ERR (latched from `eng_err` at completion), with all other bits 0. While BSY is 1, status reads exactly 80h.
- R10: The error register (offset 1 read) returns `eng_diag_code` after command 90h, `eng_sense_code` after command 03h, and `eng_err_code` after any other command. It reads 0 while busy.
- R11: Offset 1 writes go to the features register, which drives `cmd_feature`, and never to the error byte. Task file registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_ctl | input | 1 | Control-block select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_byte | input | 1 | Byte access to the data register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| xfer_load | input | 1 | Load data register from the buffer side |
| xfer_in | input | 16 | Word from the buffer side |
| xfer_word | output | 16 | Current data register contents |
| eng_done | input | 1 | Command completion pulse |
| eng_err | input | 1 | Completion ended in error |
| eng_drq | input | 1 | Engine is ready to move data |
| eng_err_code | input | 8 | Error byte for ordinary commands |
| eng_diag_code | input | 8 | Diagnostic result byte |
| eng_sense_code | input | 8 | Extended error byte |
| cmd_go | output | 1 | One-cycle command start |
| cmd_code | output | 8 | Accepted command code |
| cmd_feature | output | 8 | Features register |
| sec_count | output | 9 | Effective sector count, 1 to 256 |
| addr_is_lba | output | 1 | Address translation is LBA |
| lba_addr | output | 28 | Logical block address |
| chs_cyl | output | 16 | Cylinder |
| chs_head | output | 4 | Head |
| chs_sector | output | 8 | Starting sector |
| dev_reset | output | 1 | Soft reset is active |
| intrq | output | 1 | Interrupt request |

## Verification
The bench drives a count of zero and sets up both address modes with all-ones fields. A design that missed the 256 mapping, or swapped or truncated a byte or the head nibble, would show a wrong `sec_count`, `lba_addr` or CHS triple. It reads alternate status with an interrupt pending and reads status afterwards, so a block that cleared on the wrong read, or never cleared, leaves `intrq` in the wrong state. It also checks the masked request that appears once the disable bit is lifted, and a completion pulse with no busy command. During soft reset it writes the task file and issues a command: a design that let either through would show a stored byte or a `cmd_go`. It issues 90h, 03h and an ordinary command and compares the error byte both while busy and after completion, which catches a stale or wrong code source.

// File: rtl/tfile_pkg.sv
package tfile_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int OFS_W  = 3;
    localparam int HEAD_W = 4;
    localparam int LBA_W  = 3 * BYTE_W + HEAD_W;
    localparam int CNT_W  = BYTE_W + 1;

    localparam logic [BYTE_W-1:0] CMD_DIAG  = 8'h90;
    localparam logic [BYTE_W-1:0] CMD_SENSE = 8'h03;

    // status byte bit positions
    localparam int ST_BSY  = 7;
    localparam int ST_DRDY = 6;
    localparam int ST_DRQ  = 3;
    localparam int ST_ERR  = 0;

    // device control and drive/head bit positions
    localparam int DC_NIEN = 1;
    localparam int DC_SRST = 2;
    localparam int DH_LBA  = 6;

    typedef enum logic [1:0] {
        ES_PLAIN = 2'd0,
        ES_DIAG  = 2'd1,
        ES_SENSE = 2'd2
    } esrc_e;

    typedef struct packed {
        logic data;
        logic feat;
        logic cnt;
        logic sect;
        logic cyll;
        logic cylh;
        logic dh;
        logic cmd;
        logic devctl;
    } wsel_t;

    typedef struct packed {
        logic data;
        logic err;
        logic cnt;
        logic sect;
        logic cyll;
        logic cylh;
        logic dh;
        logic stat;
        logic alt;
    } rsel_t;
endpackage

// File: rtl/tfile_decode.sv
module tfile_decode
    import tfile_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  logic             ctl,
    input  logic             rd,
    input  logic             wr,
    output wsel_t            wsel,
    output rsel_t            rsel
);
    localparam logic [OFS_W-1:0] O_DATA = OFS_W'(0);
    localparam logic [OFS_W-1:0] O_ERR  = OFS_W'(1);
    localparam logic [OFS_W-1:0] O_CNT  = OFS_W'(2);
    localparam logic [OFS_W-1:0] O_SECT = OFS_W'(3);
    localparam logic [OFS_W-1:0] O_CYLL = OFS_W'(4);
    localparam logic [OFS_W-1:0] O_CYLH = OFS_W'(5);
    localparam logic [OFS_W-1:0] O_DH   = OFS_W'(6);
    localparam logic [OFS_W-1:0] O_STAT = OFS_W'(7);

    always_comb begin
        wsel = '0;
        rsel = '0;
        if (!ctl) begin
            case (ofs)
                O_DATA: begin wsel.data = wr; rsel.data = rd; end
                O_ERR:  begin wsel.feat = wr; rsel.err  = rd; end
                O_CNT:  begin wsel.cnt  = wr; rsel.cnt  = rd; end
                O_SECT: begin wsel.sect = wr; rsel.sect = rd; end
                O_CYLL: begin wsel.cyll = wr; rsel.cyll = rd; end
                O_CYLH: begin wsel.cylh = wr; rsel.cylh = rd; end
                O_DH:   begin wsel.dh   = wr; rsel.dh   = rd; end
                O_STAT: begin wsel.cmd  = wr; rsel.stat = rd; end
                default: ;
            endcase
        end else if (ofs == O_DH) begin
            wsel.devctl = wr;
            rsel.alt    = rd;
        end
    end
endmodule

// File: rtl/tfile_xlat.sv
module tfile_xlat
    import tfile_pkg::*;
(
    input  logic [BYTE_W-1:0] cnt,
    input  logic [BYTE_W-1:0] sect,
    input  logic [BYTE_W-1:0] cyll,
    input  logic [BYTE_W-1:0] cylh,
    input  logic [BYTE_W-1:0] dh,
    output logic [CNT_W-1:0]  eff_cnt,
    output logic              is_lba,
    output logic [LBA_W-1:0]  lba,
    output logic [WORD_W-1:0] cyl,
    output logic [HEAD_W-1:0] head,
    output logic [BYTE_W-1:0] sector
);
    always_comb begin
        eff_cnt = (cnt == '0) ? {1'b1, {BYTE_W{1'b0}}} : {1'b0, cnt};
        is_lba  = dh[DH_LBA];
        lba     = '0;
        cyl     = '0;
        head    = '0;
        sector  = '0;
        if (is_lba) begin
            lba = {dh[HEAD_W-1:0], cylh, cyll, sect};
        end else begin
            cyl    = {cylh, cyll};
            head   = dh[HEAD_W-1:0];
            sector = sect;
        end
    end
endmodule

// File: rtl/tfile_core.sv
module tfile_core
    import tfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wsel_t             wsel,
    input  rsel_t             rsel,
    input  logic              bus_byte,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              xfer_load,
    input  logic [WORD_W-1:0] xfer_in,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              eng_drq,
    input  logic [BYTE_W-1:0] eng_err_code,
    input  logic [BYTE_W-1:0] eng_diag_code,
    input  logic [BYTE_W-1:0] eng_sense_code,
    output logic [WORD_W-1:0] data_o,
    output logic [BYTE_W-1:0] feat_o,
    output logic [BYTE_W-1:0] cnt_o,
    output logic [BYTE_W-1:0] sect_o,
    output logic [BYTE_W-1:0] cyll_o,
    output logic [BYTE_W-1:0] cylh_o,
    output logic [BYTE_W-1:0] dh_o,
    output logic              go_o,
    output logic [BYTE_W-1:0] code_o,
    output logic              srst_o,
    output logic              irq_o
);
    localparam int PAD_W = WORD_W - BYTE_W;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [BYTE_W-1:0] feat;
        logic [BYTE_W-1:0] cnt;
        logic [BYTE_W-1:0] sect;
        logic [BYTE_W-1:0] cyll;
        logic [BYTE_W-1:0] cylh;
        logic [BYTE_W-1:0] dh;
        logic [BYTE_W-1:0] cmd;
        logic              nien;
        logic              srst;
        logic              bsy;
        logic              err;
        logic              irq;
        logic              go;
        esrc_e             esrc;
    } core_t;

    core_t st_d, st_q;

    logic              busy_eff;
    logic [BYTE_W-1:0] stat_byte;
    logic [BYTE_W-1:0] err_byte;
    logic [BYTE_W-1:0] wlo;

    assign busy_eff = st_q.bsy | st_q.srst;
    assign wlo      = bus_wdata[BYTE_W-1:0];

    // status and error bytes seen by the host
    always_comb begin
        stat_byte = '0;
        if (busy_eff) begin
            stat_byte[ST_BSY] = 1'b1;
        end else begin
            stat_byte[ST_DRDY] = 1'b1;
            stat_byte[ST_DRQ]  = eng_drq;
            stat_byte[ST_ERR]  = st_q.err;
        end
        err_byte = '0;
        if (!busy_eff) begin
            case (st_q.esrc)
                ES_DIAG:  err_byte = eng_diag_code;
                ES_SENSE: err_byte = eng_sense_code;
                default:  err_byte = eng_err_code;
            endcase
        end
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (rsel.data) begin
            bus_rdata = bus_byte ? {{PAD_W{1'b0}}, st_q.data[BYTE_W-1:0]} : st_q.data;
        end
        if (rsel.err)  bus_rdata = {{PAD_W{1'b0}}, err_byte};
        if (rsel.cnt)  bus_rdata = {{PAD_W{1'b0}}, st_q.cnt};
        if (rsel.sect) bus_rdata = {{PAD_W{1'b0}}, st_q.sect};
        if (rsel.cyll) bus_rdata = {{PAD_W{1'b0}}, st_q.cyll};
        if (rsel.cylh) bus_rdata = {{PAD_W{1'b0}}, st_q.cylh};
        if (rsel.dh)   bus_rdata = {{PAD_W{1'b0}}, st_q.dh};
        if (rsel.stat || rsel.alt) bus_rdata = {{PAD_W{1'b0}}, stat_byte};
    end

    // next-state computation
    always_comb begin
        st_d    = st_q;
        st_d.go = 1'b0;

        if (xfer_load) st_d.data = xfer_in;
        if (wsel.data) begin
            if (bus_byte) st_d.data[BYTE_W-1:0] = wlo;
            else          st_d.data = bus_wdata;
        end

        if (!st_q.srst) begin
            if (wsel.feat) st_d.feat = wlo;
            if (wsel.cnt)  st_d.cnt  = wlo;
            if (wsel.sect) st_d.sect = wlo;
            if (wsel.cyll) st_d.cyll = wlo;
            if (wsel.cylh) st_d.cylh = wlo;
            if (wsel.dh)   st_d.dh   = wlo;
        end

        if (wsel.devctl) begin
            st_d.nien = wlo[DC_NIEN];
            st_d.srst = wlo[DC_SRST];
        end

        if (rsel.stat) st_d.irq = 1'b0;

        if (eng_done && st_q.bsy) begin
            st_d.bsy = 1'b0;
            st_d.err = eng_err;
            st_d.irq = 1'b1;
        end

        if (wsel.cmd && !busy_eff) begin
            st_d.go  = 1'b1;
            st_d.cmd = wlo;
            st_d.bsy = 1'b1;
            st_d.err = 1'b0;
            st_d.irq = 1'b0;
            if (wlo == CMD_DIAG)       st_d.esrc = ES_DIAG;
            else if (wlo == CMD_SENSE) st_d.esrc = ES_SENSE;
            else                       st_d.esrc = ES_PLAIN;
        end

        if (st_q.srst) begin
            st_d.feat = '0;
            st_d.cnt  = '0;
            st_d.sect = '0;
            st_d.cyll = '0;
            st_d.cylh = '0;
            st_d.dh   = '0;
            st_d.bsy  = 1'b0;
            st_d.err  = 1'b0;
            st_d.irq  = 1'b0;
            st_d.esrc = ES_PLAIN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign feat_o = st_q.feat;
    assign cnt_o  = st_q.cnt;
    assign sect_o = st_q.sect;
    assign cyll_o = st_q.cyll;
    assign cylh_o = st_q.cylh;
    assign dh_o   = st_q.dh;
    assign go_o   = st_q.go;
    assign code_o = st_q.cmd;
    assign srst_o = st_q.srst;
    assign irq_o  = st_q.irq & ~st_q.nien;
endmodule

// File: rtl/tfile_regs.sv
module tfile_regs
    import tfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic              bus_ctl,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_byte,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              xfer_load,
    input  logic [WORD_W-1:0] xfer_in,
    output logic [WORD_W-1:0] xfer_word,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              eng_drq,
    input  logic [BYTE_W-1:0] eng_err_code,
    input  logic [BYTE_W-1:0] eng_diag_code,
    input  logic [BYTE_W-1:0] eng_sense_code,
    output logic              cmd_go,
    output logic [BYTE_W-1:0] cmd_code,
    output logic [BYTE_W-1:0] cmd_feature,
    output logic [CNT_W-1:0]  sec_count,
    output logic              addr_is_lba,
    output logic [LBA_W-1:0]  lba_addr,
    output logic [WORD_W-1:0] chs_cyl,
    output logic [HEAD_W-1:0] chs_head,
    output logic [BYTE_W-1:0] chs_sector,
    output logic              dev_reset,
    output logic              intrq
);
    wsel_t             wsel;
    rsel_t             rsel;
    logic [BYTE_W-1:0] cnt_r, sect_r, cyll_r, cylh_r, dh_r;

    tfile_decode u_dec (
        .ofs  (bus_addr),
        .ctl  (bus_ctl),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .wsel (wsel),
        .rsel (rsel)
    );

    tfile_core u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .wsel           (wsel),
        .rsel           (rsel),
        .bus_byte       (bus_byte),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .xfer_load      (xfer_load),
        .xfer_in        (xfer_in),
        .eng_done       (eng_done),
        .eng_err        (eng_err),
        .eng_drq        (eng_drq),
        .eng_err_code   (eng_err_code),
        .eng_diag_code  (eng_diag_code),
        .eng_sense_code (eng_sense_code),
        .data_o         (xfer_word),
        .feat_o         (cmd_feature),
        .cnt_o          (cnt_r),
        .sect_o         (sect_r),
        .cyll_o         (cyll_r),
        .cylh_o         (cylh_r),
        .dh_o           (dh_r),
        .go_o           (cmd_go),
        .code_o         (cmd_code),
        .srst_o         (dev_reset),
        .irq_o          (intrq)
    );

    tfile_xlat u_xlat (
        .cnt     (cnt_r),
        .sect    (sect_r),
        .cyll    (cyll_r),
        .cylh    (cylh_r),
        .dh      (dh_r),
        .eff_cnt (sec_count),
        .is_lba  (addr_is_lba),
        .lba     (lba_addr),
        .cyl     (chs_cyl),
        .head    (chs_head),
        .sector  (chs_sector)
    );
endmodule

// File: rtl/tfile_regs_chk.sv
module tfile_regs_chk
    import tfile_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OFS_W-1:0]  bus_addr,
    input logic              bus_ctl,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              eng_done,
    input logic              cmd_go,
    input logic [CNT_W-1:0]  sec_count,
    input logic              addr_is_lba,
    input logic [LBA_W-1:0]  lba_addr,
    input logic [WORD_W-1:0] chs_cyl,
    input logic [HEAD_W-1:0] chs_head,
    input logic [BYTE_W-1:0] chs_sector,
    input logic              dev_reset,
    input logic              intrq
);
    localparam logic [OFS_W-1:0] O_SEL6 = OFS_W'(6);
    localparam logic [OFS_W-1:0] O_SEL7 = OFS_W'(7);
    localparam logic [CNT_W-1:0] CNT_MAX = {1'b1, {BYTE_W{1'b0}}};

    // R2: effective count always within 1..256
    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_count != '0) && (sec_count <= CNT_MAX));

    // R4: in LBA mode the CHS outputs are quiet
    a_r4_chs_quiet_in_lba: assert property (@(posedge clk) disable iff (!rst_n)
        addr_is_lba |-> (chs_cyl == '0 && chs_head == '0 && chs_sector == '0));

    // R5: a status read with no completion leaves no interrupt
    a_r5_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ctl && bus_addr == O_SEL7 && !eng_done) |=> !intrq);

    // R5: alternate status read keeps an asserted interrupt
    a_r5_alt_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ctl && bus_addr == O_SEL6 && !bus_wr && intrq && !dev_reset) |=> intrq);

    // R6: interrupt rises only after completion or an unmask write
    a_r6_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intrq) |-> ($past(eng_done) || $past(bus_wr && bus_ctl && bus_addr == O_SEL6)));

    // R7: status reads busy during soft reset
    a_r7_srst_shows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_reset && bus_rd && !bus_ctl && bus_addr == O_SEL7) |-> bus_rdata[ST_BSY]);

    // R7: no command starts during soft reset
    a_r7_no_go_in_srst: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |=> !cmd_go);

    // R8: command strobe lasts one cycle
    a_r8_go_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> !cmd_go);

    // R8: command strobe follows a command write
    a_r8_go_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> $past(bus_wr && !bus_ctl && bus_addr == O_SEL7));
endmodule

bind tfile_regs tfile_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_ctl     (bus_ctl),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .eng_done    (eng_done),
    .cmd_go      (cmd_go),
    .sec_count   (sec_count),
    .addr_is_lba (addr_is_lba),
    .lba_addr    (lba_addr),
    .chs_cyl     (chs_cyl),
    .chs_head    (chs_head),
    .chs_sector  (chs_sector),
    .dev_reset   (dev_reset),
    .intrq       (intrq)
);

// File: tb/tfile_regs_test.sv
`timescale 1ns/1ps
module tfile_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_ctl = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        xfer_load = 1'b0;
    logic [15:0] xfer_in = '0;
    logic [15:0] xfer_word;
    logic        eng_done = 1'b0, eng_err = 1'b0, eng_drq = 1'b0;
    logic [7:0]  eng_err_code = 8'h04, eng_diag_code = 8'h01, eng_sense_code = 8'h21;
    logic        cmd_go;
    logic [7:0]  cmd_code, cmd_feature;
    logic [8:0]  sec_count;
    logic        addr_is_lba;
    logic [27:0] lba_addr;
    logic [15:0] chs_cyl;
    logic [3:0]  chs_head;
    logic [7:0]  chs_sector;
    logic        dev_reset, intrq;

    int n_chk = 0;
    int n_fail = 0;
    bit reported = 1'b0;

    always #10 clk = ~clk;

    tfile_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_ctl(bus_ctl),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_byte(bus_byte),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xfer_load(xfer_load), .xfer_in(xfer_in), .xfer_word(xfer_word),
        .eng_done(eng_done), .eng_err(eng_err), .eng_drq(eng_drq),
        .eng_err_code(eng_err_code), .eng_diag_code(eng_diag_code),
        .eng_sense_code(eng_sense_code), .cmd_go(cmd_go), .cmd_code(cmd_code),
        .cmd_feature(cmd_feature), .sec_count(sec_count),
        .addr_is_lba(addr_is_lba), .lba_addr(lba_addr), .chs_cyl(chs_cyl),
        .chs_head(chs_head), .chs_sector(chs_sector),
        .dev_reset(dev_reset), .intrq(intrq)
    );

    // {count, sector, cyl low, cyl high, drive/head, expected effective count}
    localparam logic [48:0] VEC [0:5] = '{
        {8'h00, 8'h11, 8'h22, 8'h33, 8'hE5, 9'd256},
        {8'h01, 8'h01, 8'h00, 8'h00, 8'hA0, 9'd1},
        {8'hFF, 8'h3F, 8'hFF, 8'h03, 8'hAF, 9'd255},
        {8'h80, 8'hFF, 8'hFF, 8'hFF, 8'h4F, 9'd128},
        {8'h02, 8'h00, 8'h00, 8'h00, 8'h40, 9'd2},
        {8'h10, 8'h9A, 8'h78, 8'h56, 8'h0B, 9'd16}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic c, input logic b,
                      input logic [15:0] d, output logic go);
        @(negedge clk);
        bus_addr = a; bus_ctl = c; bus_byte = b; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_byte = 1'b0;
        go = cmd_go;
    endtask

    task automatic rd(input logic [2:0] a, input logic c, input logic b,
                      output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_ctl = c; bus_byte = b; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic done_pulse(input logic e);
        @(negedge clk);
        eng_done = 1'b1; eng_err = e;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        logic        go;
        logic [15:0] r;
        logic [7:0]  cnt, sect, cyll, cylh, dh;
        logic [8:0]  ec;
        logic [27:0] exp_lba;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(3'd7, 1'b0, 1'b0, r);
        chk("R9 reset status", r, 16'h0040);
        chk("R6 reset intrq", intrq, 0);
        chk("R8 reset cmd_go", cmd_go, 0);
        chk("R2 reset count", sec_count, 9'd256);

        // address translation vectors
        for (int i = 0; i < 6; i++) begin
            {cnt, sect, cyll, cylh, dh, ec} = VEC[i];
            wr(3'd2, 1'b0, 1'b0, {8'h00, cnt}, go);
            wr(3'd3, 1'b0, 1'b0, {8'h00, sect}, go);
            wr(3'd4, 1'b0, 1'b0, {8'h00, cyll}, go);
            wr(3'd5, 1'b0, 1'b0, {8'h00, cylh}, go);
            wr(3'd6, 1'b0, 1'b0, {8'h00, dh}, go);
            exp_lba = dh[6] ? {dh[3:0], cylh, cyll, sect} : 28'h0;
            chk("R2 effective count", sec_count, ec);
            chk("R3 lba flag", addr_is_lba, dh[6]);
            chk("R3 lba address", lba_addr, exp_lba);
            chk("R4 cylinder", chs_cyl, dh[6] ? 16'h0 : {cylh, cyll});
            chk("R4 head", chs_head, dh[6] ? 4'h0 : dh[3:0]);
            chk("R4 sector", chs_sector, dh[6] ? 8'h0 : sect);
            rd(3'd6, 1'b0, 1'b0, r);
            chk("R11 drive/head readback", r, {8'h00, dh});
            rd(3'd4, 1'b0, 1'b0, r);
            chk("R11 cyl low readback", r, {8'h00, cyll});
        end

        // R1 data register word and byte access
        wr(3'd0, 1'b0, 1'b0, 16'h1234, go);
        rd(3'd0, 1'b0, 1'b0, r);
        chk("R1 word write/read", r, 16'h1234);
        wr(3'd0, 1'b0, 1'b1, 16'h55AB, go);
        rd(3'd0, 1'b0, 1'b0, r);
        chk("R1 byte write keeps high byte", r, 16'h12AB);
        rd(3'd0, 1'b0, 1'b1, r);
        chk("R1 byte read", r, 16'h00AB);
        @(negedge clk); xfer_in = 16'hBEEF; xfer_load = 1'b1;
        @(negedge clk); xfer_load = 1'b0;
        chk("R1 buffer load", xfer_word, 16'hBEEF);

        // R11 features register
        wr(3'd1, 1'b0, 1'b0, 16'h00C3, go);
        chk("R11 feature output", cmd_feature, 8'hC3);
        rd(3'd1, 1'b0, 1'b0, r);
        chk("R11 offset 1 reads error not feature", r, 16'h0004);

        // R6 completion while idle has no effect
        done_pulse(1'b0);
        chk("R6 idle done ignored", intrq, 0);

        // R8 command start
        wr(3'd7, 1'b0, 1'b0, 16'h0020, go);
        chk("R8 go pulse", go, 1);
        chk("R8 code", cmd_code, 8'h20);
        @(negedge clk);
        chk("R8 go ends", cmd_go, 0);
        rd(3'd7, 1'b0, 1'b0, r);
        chk("R9 busy status", r, 16'h0080);
        eng_drq = 1'b1;
        rd(3'd6, 1'b1, 1'b0, r);
        chk("R9 busy hides drq", r, 16'h0080);
        eng_drq = 1'b0;
        rd(3'd1, 1'b0, 1'b0, r);
        chk("R10 error reads 0 while busy", r, 16'h0000);
        wr(3'd7, 1'b0, 1'b0, 16'h00C8, go);
        chk("R8 write while busy no go", go, 0);
        chk("R8 code kept", cmd_code, 8'h20);
        done_pulse(1'b1);
        chk("R6 intrq after done", intrq, 1);
        rd(3'd6, 1'b1, 1'b0, r);
        chk("R5 alt status value", r, 16'h0041);
        chk("R5 alt read keeps intrq", intrq, 1);
        rd(3'd7, 1'b0, 1'b0, r);
        chk("R5 status value", r, 16'h0041);
        chk("R5 status read clears intrq", intrq, 0);
        rd(3'd1, 1'b0, 1'b0, r);
        chk("R10 plain error code", r, 16'h0004);
        eng_drq = 1'b1;
        rd(3'd7, 1'b0, 1'b0, r);
        chk("R9 drq bit", r, 16'h0049);
        eng_drq = 1'b0;

        // R6 interrupt masking
        wr(3'd6, 1'b1, 1'b0, 16'h0002, go);
        wr(3'd7, 1'b0, 1'b0, 16'h0090, go);
        chk("R8 diag go", go, 1);
        done_pulse(1'b0);
        chk("R6 masked intrq", intrq, 0);
        wr(3'd6, 1'b1, 1'b0, 16'h0000, go);
        chk("R6 unmask shows pending", intrq, 1);
        rd(3'd1, 1'b0, 1'b0, r);
        chk("R10 diag code", r, 16'h0001);
        rd(3'd7, 1'b0, 1'b0, r);
        chk("R9 ERR cleared by new command", r, 16'h0040);

        // R10 sense code
        wr(3'd7, 1'b0, 1'b0, 16'h0003, go);
        done_pulse(1'b0);
        rd(3'd1, 1'b0, 1'b0, r);
        chk("R10 sense code", r, 16'h0021);

        // R7 soft reset (intrq pending from the 03h command)
        wr(3'd3, 1'b0, 1'b0, 16'h005A, go);
        wr(3'd6, 1'b1, 1'b0, 16'h0004, go);
        chk("R7 dev_reset on", dev_reset, 1);
        rd(3'd7, 1'b0, 1'b0, r);
        chk("R7 status busy", r, 16'h0080);
        chk("R7 intrq cleared", intrq, 0);
        rd(3'd3, 1'b0, 1'b0, r);
        chk("R7 sector cleared", r, 16'h0000);
        wr(3'd3, 1'b0, 1'b0, 16'h0033, go);
        rd(3'd3, 1'b0, 1'b0, r);
        chk("R7 write ignored", r, 16'h0000);
        wr(3'd7, 1'b0, 1'b0, 16'h0020, go);
        chk("R7 command dropped", go, 0);
        wr(3'd6, 1'b1, 1'b0, 16'h0000, go);
        chk("R7 dev_reset off", dev_reset, 0);
        rd(3'd7, 1'b0, 1'b0, r);
        chk("R7 status ready", r, 16'h0040);
        rd(3'd6, 1'b0, 1'b0, r);
        chk("R7 drive/head still 0", r, 16'h0000);
        wr(3'd3, 1'b0, 1'b0, 16'h0044, go);
        rd(3'd3, 1'b0, 1'b0, r);
        chk("R7 writes accepted again", r, 16'h0044);

        report();
    end
endmodule